// File: doc/BRIEF.md
# Recursive Accuracy-Configurable Approximate Multiplier

This block is a purely combinational unsigned multiplier for error-tolerant datapaths such as image and signal filters. Each operand is split in half, and the four half-width products are formed by smaller copies of the same structure. The split repeats until every product is a 2-bit by 2-bit leaf cell. An exact adder tree sums the partial products back up. All leaf cells work in parallel, so the full product is available in the same cycle the operands are presented.

A compile-time parameter selects one leaf-cell flavour for the whole instance:
- an exact cell;
- a cell that caps its output at three bits;
- a cell that copies the product's top bit into its bottom bit.

A second parameter adds a small correction path to the approximate flavours. Each leaf cell has its own accuracy-enable bit. When that bit is high, the cell's known wrong answers are repaired, so software or a controller can trade power for precision region by region. The operand width is a power of two of at least 2; the bench uses 4, 8 and 16.

Top module: `acm_multiplier`

## Requirements
- R1: The product equals `PLL + (PHL << H) + (PLH << H) + (PHH << 2H)`, where H is half the operand width at each level and PLL, PHL, PLH, PHH are the low×low, xhigh×ylow, xlow×yhigh and high×high half products. The enable vector `acc_en` has (OPW/2)^2 bits, for example 64 at 16x16. Bit k drives the leaf selected by the base-4 digits of k, most significant digit at the top level. Digit 0 means low×low, 1 means x-high×y-low, 2 means x-low×y-high and 3 means high×high.
- R2: With the exact cell flavour, the product equals x*y for every operand pair, whatever `acc_en` holds.
- R3: The three-bit cell gives the exact 2x2 product except for 3x3, which gives 7.
- R4: In the corrected three-bit cell, a set enable bit adds 2 to the 3x3 result, giving 9.
- R5: The mirrored-LSB cell drives product bit 0 from bit 3. This gives 1x1=0, 1x3=2 and 3x1=2, and the exact product elsewhere.
- R6: In the corrected mirrored-LSB cell, a set enable bit inverts bit 0 for exactly those three input pairs.
- R7: Without the correction option, `acc_en` has no effect on the product.
- R8: With a corrected flavour and every enable bit set, the product equals x*y for every operand pair.
- R9: At 4x4 with all enables clear, the mirrored-LSB cell gives 119 wrong products out of 256, with worst error 25 occurring 7 times. The three-bit cell gives 49 wrong products, with worst error 50 occurring once.
- R10: At 8x8 with all enables clear, the three-bit cell gives 30625 wrong products, with worst error 14450 occurring once. The mirrored-LSB cell gives 53375 wrong products, with worst error 7225 occurring 31 times.
- R11: The product never exceeds x*y, and a zero operand gives a zero product.
- R12: The product settles combinationally in the same cycle the operands are applied; there is no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | OPW | Multiplicand, unsigned |
| op_y | input | OPW | Multiplier, unsigned |
| acc_en | input | (OPW/2)^2 | Per-leaf accuracy enable, indexed as in R1 |
| prod | output | 2*OPW | Full-width product |

## Verification
The bench builds 8x8 instances of every flavour, with and without correction, and 4x4 instances of both approximate flavours. It sweeps all 65536 8-bit operand pairs once and reads the 4x4 results from the pairs whose upper nibbles are zero. This puts the exhaustive error counts and worst-case figures of R9 and R10 within reach, together with the full correctness of corrected instances under all-high enables. A 16x16 mirrored-LSB instance with all digits equal to 1 walks a single enable bit over all 64 leaves. This exposes the enable-to-leaf ordering and the partial-product offsets at three levels of recursion.

// File: rtl/acm_pkg.sv
package acm_pkg;
  typedef enum logic [1:0] {
    CELL_EXACT  = 2'd0,
    CELL_TRUNC3 = 2'd1,
    CELL_MIRROR = 2'd2
  } cell_kind_e;
endpackage

// File: rtl/acm_cell.sv
module acm_cell
  import acm_pkg::*;
#(
  parameter cell_kind_e KIND    = CELL_EXACT,
  parameter bit         CORRECT = 1'b0
) (
  input  logic [1:0] a,
  input  logic [1:0] b,
  input  logic       fix,
  output logic [3:0] p
);
  logic [3:0] full;
  assign full = {2'b00, a} * {2'b00, b};

  if (KIND == CELL_TRUNC3) begin : g_trunc
    logic       hit;
    logic [2:0] short_p;
    logic       unused_msb;
    assign unused_msb = full[3];
    assign hit        = &{a, b};
    // only 3x3 overflows three bits; it is pinned to 7
    assign short_p    = hit ? 3'd7 : full[2:0];
    if (CORRECT) begin : g_fix
      assign p = {1'b0, short_p} + {2'b00, hit & fix, 1'b0};
    end else begin : g_raw
      logic unused_fix;
      assign unused_fix = fix;
      assign p = {1'b0, short_p};
    end
  end else if (KIND == CELL_MIRROR) begin : g_mirror
    logic unused_lsb;
    assign unused_lsb = full[0];
    if (CORRECT) begin : g_fix
      logic miss;
      // odd products other than 9 lose their low bit
      assign miss = a[0] & b[0] & ~(a[1] & b[1]);
      assign p = {full[3:1], full[3] ^ (fix & miss)};
    end else begin : g_raw
      logic unused_fix;
      assign unused_fix = fix;
      assign p = {full[3:1], full[3]};
    end
  end else begin : g_exact
    logic unused_fix;
    assign unused_fix = fix;
    assign p = full;
  end
endmodule

// File: rtl/acm_sum.sv
module acm_sum #(
  parameter int H = 1
) (
  input  logic [2*H-1:0] ll,
  input  logic [2*H-1:0] hl,
  input  logic [2*H-1:0] lh,
  input  logic [2*H-1:0] hh,
  output logic [4*H-1:0] s
);
  localparam int PW = 2 * H;
  logic [4*H-1:0] e_ll, e_hl, e_lh, e_hh;
  assign e_ll = {{PW{1'b0}}, ll};
  assign e_hl = {{PW{1'b0}}, hl} << H;
  assign e_lh = {{PW{1'b0}}, lh} << H;
  assign e_hh = {{PW{1'b0}}, hh} << PW;
  assign s    = e_ll + e_hl + e_lh + e_hh;
endmodule

// File: rtl/acm_node.sv
module acm_node
  import acm_pkg::*;
#(
  parameter int         W       = 8,
  parameter cell_kind_e KIND    = CELL_EXACT,
  parameter bit         CORRECT = 1'b0
) (
  input  logic [W-1:0]             a,
  input  logic [W-1:0]             b,
  input  logic [(W/2)*(W/2)-1:0]   en,
  output logic [2*W-1:0]           p
);
  localparam int NC = (W / 2) * (W / 2);

  if (W == 2) begin : g_leaf
    acm_cell #(.KIND(KIND), .CORRECT(CORRECT)) u_cell (
      .a(a), .b(b), .fix(en[0]), .p(p)
    );
  end else begin : g_split
    localparam int H   = W / 2;
    localparam int SNC = NC / 4;
    logic [W-1:0] pp [4];
    for (genvar q = 0; q < 4; q++) begin : g_quad
      logic [H-1:0] sa, sb;
      assign sa = (q % 2 == 1) ? a[W-1:H] : a[H-1:0];
      assign sb = (q / 2 == 1) ? b[W-1:H] : b[H-1:0];
      acm_node #(.W(H), .KIND(KIND), .CORRECT(CORRECT)) u_sub (
        .a(sa), .b(sb), .en(en[q*SNC +: SNC]), .p(pp[q])
      );
    end
    acm_sum #(.H(H)) u_sum (
      .ll(pp[0]), .hl(pp[1]), .lh(pp[2]), .hh(pp[3]), .s(p)
    );
  end
endmodule

// File: rtl/acm_multiplier.sv
module acm_multiplier
  import acm_pkg::*;
#(
  parameter int         OPW     = 8,
  parameter cell_kind_e KIND    = CELL_MIRROR,
  parameter bit         CORRECT = 1'b1
) (
  input  logic [OPW-1:0]               op_x,
  input  logic [OPW-1:0]               op_y,
  input  logic [(OPW/2)*(OPW/2)-1:0]   acc_en,
  output logic [2*OPW-1:0]             prod
);
  localparam int NCELL = (OPW / 2) * (OPW / 2);

  logic [NCELL-1:0] en_w;
  assign en_w = acc_en;

  acm_node #(.W(OPW), .KIND(KIND), .CORRECT(CORRECT)) u_root (
    .a(op_x), .b(op_y), .en(en_w), .p(prod)
  );
endmodule

// File: rtl/acm_multiplier_chk.sv
module acm_multiplier_chk
  import acm_pkg::*;
#(
  parameter int         OPW     = 8,
  parameter cell_kind_e KIND    = CELL_MIRROR,
  parameter bit         CORRECT = 1'b1
) (
  input logic [OPW-1:0]             op_x,
  input logic [OPW-1:0]             op_y,
  input logic [(OPW/2)*(OPW/2)-1:0] acc_en,
  input logic [2*OPW-1:0]           prod
);
  logic [2*OPW-1:0] full, gap;
  assign full = {{OPW{1'b0}}, op_x} * {{OPW{1'b0}}, op_y};
  assign gap  = full - prod;

  always_comb begin
    if (KIND == CELL_EXACT)
      a_r2_exact_kind: assert (prod == full);
    if (CORRECT && (&acc_en))
      a_r8_corrected_exact: assert (prod == full);
    a_r11_no_overshoot: assert (prod <= full);
    if (op_x == '0 || op_y == '0)
      a_r11_zero_operand: assert (prod == '0);
    if (KIND == CELL_TRUNC3)
      a_r3_even_gap: assert (gap[0] == 1'b0);
  end
endmodule

bind acm_multiplier acm_multiplier_chk #(
  .OPW(OPW), .KIND(KIND), .CORRECT(CORRECT)
) u_chk (
  .op_x(op_x), .op_y(op_y), .acc_en(acc_en), .prod(prod)
);

// File: tb/acm_multiplier_test.sv
module acm_multiplier_test;
  import acm_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0]  x8, y8;
  logic [15:0] x16, y16;
  logic [63:0] en16;

  logic [15:0] p_m8_off, p_m8_on, p_t8_off, p_t8_on, p_m8_raw, p_t8_raw, p_e8;
  logic [7:0]  p_m4_off, p_t4_off, p_m4_on, p_t4_on;
  logic [31:0] p_m16;

  acm_multiplier #(.OPW(8), .KIND(CELL_MIRROR), .CORRECT(1'b1)) uut (
    .op_x(x8), .op_y(y8), .acc_en(16'h0000), .prod(p_m8_off));
  acm_multiplier #(.OPW(8), .KIND(CELL_MIRROR), .CORRECT(1'b1)) uut_m8_on (
    .op_x(x8), .op_y(y8), .acc_en(16'hFFFF), .prod(p_m8_on));
  acm_multiplier #(.OPW(8), .KIND(CELL_TRUNC3), .CORRECT(1'b1)) uut_t8_off (
    .op_x(x8), .op_y(y8), .acc_en(16'h0000), .prod(p_t8_off));
  acm_multiplier #(.OPW(8), .KIND(CELL_TRUNC3), .CORRECT(1'b1)) uut_t8_on (
    .op_x(x8), .op_y(y8), .acc_en(16'hFFFF), .prod(p_t8_on));
  acm_multiplier #(.OPW(8), .KIND(CELL_MIRROR), .CORRECT(1'b0)) uut_m8_raw (
    .op_x(x8), .op_y(y8), .acc_en(16'hFFFF), .prod(p_m8_raw));
  acm_multiplier #(.OPW(8), .KIND(CELL_TRUNC3), .CORRECT(1'b0)) uut_t8_raw (
    .op_x(x8), .op_y(y8), .acc_en(16'hFFFF), .prod(p_t8_raw));
  acm_multiplier #(.OPW(8), .KIND(CELL_EXACT), .CORRECT(1'b0)) uut_e8 (
    .op_x(x8), .op_y(y8), .acc_en(16'hA5A5), .prod(p_e8));
  acm_multiplier #(.OPW(4), .KIND(CELL_MIRROR), .CORRECT(1'b1)) uut_m4_off (
    .op_x(x8[3:0]), .op_y(y8[3:0]), .acc_en(4'h0), .prod(p_m4_off));
  acm_multiplier #(.OPW(4), .KIND(CELL_TRUNC3), .CORRECT(1'b1)) uut_t4_off (
    .op_x(x8[3:0]), .op_y(y8[3:0]), .acc_en(4'h0), .prod(p_t4_off));
  acm_multiplier #(.OPW(4), .KIND(CELL_MIRROR), .CORRECT(1'b1)) uut_m4_on (
    .op_x(x8[3:0]), .op_y(y8[3:0]), .acc_en(4'hF), .prod(p_m4_on));
  acm_multiplier #(.OPW(4), .KIND(CELL_TRUNC3), .CORRECT(1'b1)) uut_t4_on (
    .op_x(x8[3:0]), .op_y(y8[3:0]), .acc_en(4'hF), .prod(p_t4_on));
  acm_multiplier #(.OPW(16), .KIND(CELL_MIRROR), .CORRECT(1'b1)) uut_m16 (
    .op_x(x16), .op_y(y16), .acc_en(en16), .prod(p_m16));

  // Reference: kind 0 exact, 1 three-bit, 2 mirrored LSB
  function automatic logic [31:0] ref_prod(input logic [15:0] x, input logic [15:0] y,
                                           input int w, input int kind, input bit fix,
                                           input logic [63:0] en);
    int nc;
    int lv;
    logic [31:0] acc;
    nc  = (w / 2) * (w / 2);
    lv  = (w == 4) ? 1 : (w == 8) ? 2 : (w == 16) ? 3 : 0;
    acc = '0;
    for (int k = 0; k < nc; k++) begin
      int xi, yi, xd, yd, v, ex;
      xi = 0;
      yi = 0;
      for (int l = 0; l < lv; l++) begin
        int d;
        d  = (k >> (2 * l)) & 3;
        xi = xi + ((d & 1) << l);
        yi = yi + (((d >> 1) & 1) << l);
      end
      xd = int'((x >> (2 * xi)) & 16'd3);
      yd = int'((y >> (2 * yi)) & 16'd3);
      ex = xd * yd;
      v  = ex;
      if (kind == 1 && xd == 3 && yd == 3) v = (fix && en[k]) ? 9 : 7;
      if (kind == 2 && ((xd == 1 && yd == 1) || (xd == 1 && yd == 3) || (xd == 3 && yd == 1)))
        v = (fix && en[k]) ? ex : ex - 1;
      acc = acc + (32'(v) << (2 * (xi + yi)));
    end
    return acc;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic apply8(input logic [7:0] a, input logic [7:0] b);
    @(posedge clk);
    #1;
    x8 = a;
    y8 = b;
    @(negedge clk);   // R12: sampled in the same cycle, no register in path
  endtask

  task automatic t_idle;
    apply8(8'd0, 8'd0);
    chk("R11 zero m8", 32'(p_m8_off), 0);
    chk("R11 zero t8", 32'(p_t8_off), 0);
    chk("R11 zero m4", 32'(p_m4_off), 0);
    apply8(8'd0, 8'd255);
    chk("R11 zero operand t8_on", 32'(p_t8_on), 0);
  endtask

  task automatic t_leaf;
    apply8(8'd1, 8'd1);
    chk("R5 1x1", 32'(p_m4_off), 0);
    chk("R6 1x1 corrected", 32'(p_m4_on), 1);
    apply8(8'd1, 8'd3);
    chk("R5 1x3", 32'(p_m4_off), 2);
    chk("R6 1x3 corrected", 32'(p_m4_on), 3);
    apply8(8'd3, 8'd1);
    chk("R5 3x1", 32'(p_m4_off), 2);
    apply8(8'd3, 8'd3);
    chk("R3 3x3", 32'(p_t4_off), 7);
    chk("R4 3x3 corrected", 32'(p_t4_on), 9);
    chk("R5 3x3 exact", 32'(p_m4_off), 9);
    apply8(8'd2, 8'd3);
    chk("R3 2x3 exact", 32'(p_t4_off), 6);
    chk("R5 2x3 exact", 32'(p_m4_off), 6);
  endtask

  task automatic t_sweep;
    int wrong[4], mx[4], nmx[4];
    for (int j = 0; j < 4; j++) begin wrong[j] = 0; mx[j] = 0; nmx[j] = 0; end
    for (int i = 0; i < 65536; i++) begin
      logic [7:0] a, b;
      logic [15:0] ex;
      int e[4];
      a  = 8'(i >> 8);
      b  = 8'(i);
      ex = 16'(a) * 16'(b);
      apply8(a, b);
      chk("R8 m8 enabled exact", 32'(p_m8_on), 32'(ex));
      chk("R8 t8 enabled exact", 32'(p_t8_on), 32'(ex));
      chk("R2 exact kind", 32'(p_e8), 32'(ex));
      chk("R5 m8 approx", 32'(p_m8_off), ref_prod(16'(a), 16'(b), 8, 2, 1'b0, '0));
      chk("R3 t8 approx", 32'(p_t8_off), ref_prod(16'(a), 16'(b), 8, 1, 1'b0, '0));
      chk("R7 m8 enable ignored", 32'(p_m8_raw), ref_prod(16'(a), 16'(b), 8, 2, 1'b0, '0));
      chk("R7 t8 enable ignored", 32'(p_t8_raw), ref_prod(16'(a), 16'(b), 8, 1, 1'b0, '0));
      e[2] = int'(ex) - int'(p_m8_off);
      e[3] = int'(ex) - int'(p_t8_off);
      if (a[7:4] == 4'd0 && b[7:4] == 4'd0) begin
        chk("R8 m4 enabled exact", 32'(p_m4_on), 32'(ex));
        chk("R8 t4 enabled exact", 32'(p_t4_on), 32'(ex));
        e[0] = int'(ex) - int'(p_m4_off);
        e[1] = int'(ex) - int'(p_t4_off);
      end else begin
        e[0] = 0;
        e[1] = 0;
      end
      for (int j = 0; j < 4; j++) begin
        if (e[j] != 0) wrong[j]++;
        if (e[j] > mx[j]) begin mx[j] = e[j]; nmx[j] = 1; end
        else if (e[j] != 0 && e[j] == mx[j]) nmx[j]++;
      end
    end
    chk("R9 m4 wrong count", 32'(wrong[0]), 119);
    chk("R9 m4 worst", 32'(mx[0]), 25);
    chk("R9 m4 worst count", 32'(nmx[0]), 7);
    chk("R9 t4 wrong count", 32'(wrong[1]), 49);
    chk("R9 t4 worst", 32'(mx[1]), 50);
    chk("R9 t4 worst count", 32'(nmx[1]), 1);
    chk("R10 m8 wrong count", 32'(wrong[2]), 53375);
    chk("R10 m8 worst", 32'(mx[2]), 7225);
    chk("R10 m8 worst count", 32'(nmx[2]), 31);
    chk("R10 t8 wrong count", 32'(wrong[3]), 30625);
    chk("R10 t8 worst", 32'(mx[3]), 14450);
    chk("R10 t8 worst count", 32'(nmx[3]), 1);
  endtask

  task automatic t_index16;
    // every 2-bit digit is 1, so each mirrored leaf yields 0 unless enabled
    @(posedge clk);
    #1;
    x16  = 16'h5555;
    y16  = 16'h5555;
    en16 = '0;
    @(negedge clk);
    chk("R1 16x16 all disabled", p_m16, 0);
    for (int k = 0; k < 64; k++) begin
      @(posedge clk);
      #1;
      en16 = 64'd1 << k;
      @(negedge clk);
      chk("R1 16x16 single leaf", p_m16, ref_prod(16'h5555, 16'h5555, 16, 2, 1'b1, 64'd1 << k));
      if (k == 0)  chk("R1 leaf 0 offset", p_m16, 32'd1);
      if (k == 1)  chk("R1 leaf 1 offset", p_m16, 32'd4);
      if (k == 2)  chk("R1 leaf 2 offset", p_m16, 32'd4);
      if (k == 3)  chk("R1 leaf 3 offset", p_m16, 32'd16);
      if (k == 63) chk("R1 leaf 63 offset", p_m16, 32'd1 << 28);
    end
    @(posedge clk);
    #1;
    en16 = '1;
    x16  = 16'hBEEF;
    y16  = 16'hC0DE;
    @(negedge clk);
    chk("R8 16x16 exact", p_m16, 32'(16'hBEEF) * 32'(16'hC0DE));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(190000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    x8    = '0;
    y8    = '0;
    x16   = '0;
    y16   = '0;
    en16  = '0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_leaf();
    t_index16();
    t_sweep();
    finish_run();
  end
endmodule